// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a three-bit synchronous counter that walks a fixed, non-binary ring of five codes: 000, 010, 011, 101, 110, and back to 000. It moves one step on every rising clock edge. A synchronous active-high reset puts it at the start of the ring. The three codes outside the ring are 001, 100 and 111. Each of them is given an explicit successor inside the ring, so a counter that wakes up in one of them rejoins the ring after a single clock.

The state register is exactly three flip-flops, and the output is that register with nothing after it. A test preload port can write any three-bit code into the register. This gives a way to place the counter in a stray code and watch it recover. Reset takes priority over preload.

The state names are SEQ_A (000), SEQ_B (010), SEQ_C (011), SEQ_D (101) and SEQ_E (110), plus STRAY_1 (001), STRAY_4 (100) and STRAY_7 (111). The ring transitions are A->B, B->C, C->D, D->E and E->A. The recovery transitions are STRAY_1->SEQ_B, STRAY_4->SEQ_E and STRAY_7->SEQ_A.

Top module: `seq5_counter`

## Requirements
- R1: When rst is 1 at a rising edge, count becomes 000 after that edge, whatever load_en and load_code are.
- R2: With rst and load_en both 0, a ring code steps to its successor at each rising edge: 000 to 010, 010 to 011, 011 to 101, 101 to 110, and 110 to 000.
- R3: With rst and load_en both 0, the stray code 001 goes to 010 at the next rising edge.
- R4: With rst and load_en both 0, the stray code 100 goes to 110 at the next rising edge.
- R5: With rst and load_en both 0, the stray code 111 goes to 000 at the next rising edge.
- R6: When rst is 0 and load_en is 1 at a rising edge, count takes the value of load_code after that edge, for any of the eight codes.
- R7: After any rising edge at which load_en is 0, count is one of the five ring codes 000, 010, 011, 101, 110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| load_en | input | 1 | Test preload strobe; loads load_code at the edge |
| load_code | input | 3 | Code written into the state register on preload |
| count | output | 3 | Registered state code |

## Verification
The block has no parameters, so the bench builds it in its single default form. That one build lets the bench reach all eight state codes. The preload port is used to drop the counter into each stray code and also into each ring code. The bench then checks the recovery step, the ring walk over several full laps, and reset winning over a simultaneous preload.

// File: rtl/seq5_pkg.sv
package seq5_pkg;

    localparam int STATE_W  = 3;
    localparam int RING_LEN = 5;

    typedef enum logic [STATE_W-1:0] {
        SEQ_A   = 3'b000,
        STRAY_1 = 3'b001,
        SEQ_B   = 3'b010,
        SEQ_C   = 3'b011,
        STRAY_4 = 3'b100,
        SEQ_D   = 3'b101,
        SEQ_E   = 3'b110,
        STRAY_7 = 3'b111
    } seq_state_e;

endpackage

// File: rtl/seq5_next.sv
module seq5_next
    import seq5_pkg::*;
(
    input  seq_state_e cur,
    output seq_state_e nxt
);

    always_comb begin
        unique case (cur)
            SEQ_A:   nxt = SEQ_B;
            SEQ_B:   nxt = SEQ_C;
            SEQ_C:   nxt = SEQ_D;
            SEQ_D:   nxt = SEQ_E;
            SEQ_E:   nxt = SEQ_A;
            STRAY_1: nxt = SEQ_B;
            STRAY_4: nxt = SEQ_E;
            STRAY_7: nxt = SEQ_A;
            default: nxt = SEQ_A;
        endcase
    end

endmodule

// File: rtl/seq5_reg.sv
module seq5_reg
    import seq5_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [STATE_W-1:0]  load_code,
    input  seq_state_e          nxt,
    output seq_state_e          cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= SEQ_A;
        end else if (load_en) begin
            cur <= seq_state_e'(load_code);
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
    import seq5_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [2:0]   load_code,
    output logic [2:0]   count
);

    seq_state_e state_q;
    seq_state_e state_d;

    seq5_next u_next (
        .cur (state_q),
        .nxt (state_d)
    );

    seq5_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_code (load_code),
        .nxt       (state_d),
        .cur       (state_q)
    );

    always_comb begin
        count = state_q;
    end

endmodule

// File: rtl/seq5_counter_chk.sv
module seq5_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_en,
    input logic [2:0] load_code,
    input logic [2:0] count
);

    logic run;
    assign run = !rst && !load_en;

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> count == 3'b000)
        else $error("R1 reset did not give 000");

    p_ring_a_r2: assert property (@(posedge clk) disable iff (rst)
        (run && count == 3'b000) |=> count == 3'b010)
        else $error("R2 000 step");
    p_ring_b_r2: assert property (@(posedge clk) disable iff (rst)
        (run && count == 3'b010) |=> count == 3'b011)
        else $error("R2 010 step");
    p_ring_c_r2: assert property (@(posedge clk) disable iff (rst)
        (run && count == 3'b011) |=> count == 3'b101)
        else $error("R2 011 step");
    p_ring_d_r2: assert property (@(posedge clk) disable iff (rst)
        (run && count == 3'b101) |=> count == 3'b110)
        else $error("R2 101 step");
    p_ring_e_r2: assert property (@(posedge clk) disable iff (rst)
        (run && count == 3'b110) |=> count == 3'b000)
        else $error("R2 110 step");

    p_stray1_r3: assert property (@(posedge clk) disable iff (rst)
        (run && count == 3'b001) |=> count == 3'b010)
        else $error("R3 001 recovery");
    p_stray4_r4: assert property (@(posedge clk) disable iff (rst)
        (run && count == 3'b100) |=> count == 3'b110)
        else $error("R4 100 recovery");
    p_stray7_r5: assert property (@(posedge clk) disable iff (rst)
        (run && count == 3'b111) |=> count == 3'b000)
        else $error("R5 111 recovery");

    p_preload_r6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count == $past(load_code))
        else $error("R6 preload");

    p_in_ring_r7: assert property (@(posedge clk) disable iff (rst)
        run |=> (count != 3'b001 && count != 3'b100 && count != 3'b111))
        else $error("R7 left the ring");

endmodule

bind seq5_counter seq5_counter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_code (load_code),
    .count     (count)
);

// File: tb/test_seq5_counter.sv
`timescale 1ns/1ps
module test_seq5_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [2:0] load_code = 3'b000;
    logic [2:0] count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int    ring[$] = '{0, 2, 3, 5, 6};
    logic [2:0] exp_q;
    bit    have_exp = 0;
    bit    was_load = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    seq5_counter i_seq5_counter (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_code (load_code),
        .count     (count)
    );

    function automatic bit on_ring(input logic [2:0] c);
        foreach (ring[k]) if (ring[k] == int'(c)) return 1;
        return 0;
    endfunction

    // behavioural reference, advanced at every rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            exp_q <= 3'b000; tag <= "R1"; have_exp <= 1; was_load <= 0;
        end else if (load_en) begin
            exp_q <= load_code; tag <= "R6"; was_load <= 1;
        end else if (have_exp) begin
            int pos;
            pos = -1;
            foreach (ring[k]) if (ring[k] == int'(exp_q)) pos = k;
            was_load <= 0;
            if (pos >= 0) begin
                exp_q <= 3'(ring[(pos + 1) % ring.size()]); tag <= "R2";
            end else if (exp_q == 3'b001) begin
                exp_q <= 3'b010; tag <= "R3";
            end else if (exp_q == 3'b100) begin
                exp_q <= 3'b110; tag <= "R4";
            end else begin
                exp_q <= 3'b000; tag <= "R5";
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (have_exp && !done) begin
            checks++;
            if (count !== exp_q) begin
                errors++;
                $display("FAIL %s count=%b expected=%b", tag, count, exp_q);
            end
            if (!was_load) begin
                checks++;
                if (!on_ring(count)) begin
                    errors++;
                    $display("FAIL R7 count=%b expected a ring code", count);
                end
            end
        end
    end

    task automatic step(input logic r, input logic le, input logic [2:0] lc);
        @(negedge clk);
        rst = r; load_en = le; load_code = lc;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        // R1: reset held over two edges
        step(1, 0, 3'b000);
        step(1, 0, 3'b000);
        // R2: three full laps of the ring
        step(0, 0, 3'b000);
        repeat (15) step(0, 0, 3'b000);
        // R3, R4, R5: preload each stray code, then let it recover
        for (int s = 0; s < 3; s++) begin
            logic [2:0] c;
            c = (s == 0) ? 3'b001 : (s == 1) ? 3'b100 : 3'b111;
            step(0, 1, c);
            repeat (4) step(0, 0, 3'b000);
        end
        // R6: preload every code, back to back and with gaps
        for (int v = 0; v < 8; v++) step(0, 1, 3'(v));
        for (int v = 7; v >= 0; v--) begin
            step(0, 1, 3'(v));
            step(0, 0, 3'b000);
        end
        // R1: reset wins over a simultaneous preload of a stray code
        step(1, 1, 3'b111);
        step(0, 0, 3'b000);
        step(0, 1, 3'b101);
        step(1, 1, 3'b011);
        repeat (6) step(0, 0, 3'b000);
        @(negedge clk);
        @(posedge clk);
        finish_run();
    end

    initial begin
        wait (cycles > 5000);
        errors++;
        $display("FAIL watchdog cycles=%0d expected under 5000", cycles);
        finish_run();
    end

endmodule